// File: doc/BRIEF.md
# Dual-Rail Power-On Reset Sequencer

This block drives the active-low reset of a microcontroller that runs from two supplies, a core rail and an I/O rail. Each rail arrives as a digital "good" flag from an analog comparator outside the block. The sequencer keeps reset asserted until the core rail reports good. It then counts a power-up delay in ticks of a slow timebase strobe. When the delay ends it also requires the I/O rail to be good, and only then does it release reset. The order of the checks is fixed: core rail first, I/O rail second.

After release, a rail that drops out causes reset to be asserted again. The drop must last a minimum number of fast clock cycles, so short glitches on either flag are ignored. Each recovery restarts the full power-up delay. A mode input selects between a short and a long delay. A one-cycle pulse marks the moment reset is released, so a downstream watchdog can start its first window.

Top module: `dual_rail_por`

## Requirements
- R1: While the synchronous input `rst` is high, and in the cycle after it, `por_rst_n` is 0 and `rst_released` is 0.
- R2: While `core_good` is 0, `por_rst_n` stays 0 whatever `io_good` and `tick` do.
- R3: With `slow_mode`=0, `por_rst_n` stays 0 after `core_good` becomes 1 until FAST_TICKS `tick` strobes have been counted. It rises with the edge that samples the last strobe if `io_good` is 1.
- R4: With `slow_mode`=1, the same holds with SLOW_TICKS strobes.
- R5: If `io_good` is 0 when the delay ends, `por_rst_n` stays 0. It rises on the first clock edge at which both `io_good` and `core_good` are sampled 1, and needs no further tick.
- R6: `rst_released` is 1 for exactly one cycle, the cycle in which `por_rst_n` has just gone from 0 to 1. It is 0 at all other times.
- R7: After release, if either `core_good` or `io_good` is sampled 0 on REACT_CYCLES consecutive clock edges, `por_rst_n` returns to 0 one edge later.
- R8: A drop of either rail flag that spans fewer than REACT_CYCLES sampling edges leaves `por_rst_n` at 1.
- R9: After any filtered loss of the core rail, whether during the delay or after release, the full power-up delay is counted again from zero before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| tick | input | 1 | Timebase strobe, one cycle wide, that advances the power-up delay |
| slow_mode | input | 1 | 0 selects the fast delay count, 1 selects the slow delay count |
| core_good | input | 1 | Core rail within regulation |
| io_good | input | 1 | I/O rail within regulation |
| por_rst_n | output | 1 | Active-low reset to the microcontroller |
| rst_released | output | 1 | One-cycle pulse when reset is released |

## Verification
A vector table tries the delay one strobe short of its count and at exactly its count, in both modes. It also runs the delay with the I/O rail absent. This separates a miscounted or swapped limit from a missing I/O check. Directed cases follow. One brings the I/O rail up late, which shows whether release waits for it and then happens without a further tick. One applies a drop one cycle shorter than the filter window and another that is clearly longer, which separates glitch rejection from fail detection. Two drop the core rail, once during the delay and once after release, to show that the full delay is counted again.

// File: rtl/por_pkg.sv
package por_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_CORE = 2'd0,
        ST_DELAY     = 2'd1,
        ST_CHECK_IO  = 2'd2,
        ST_RUN       = 2'd3
    } por_state_e;

    localparam int NUM_RAILS = 2;
    localparam int RAIL_CORE = 0;
    localparam int RAIL_IO   = 1;

endpackage

// File: rtl/por_fail_filter.sv
module por_fail_filter #(
    parameter int REACT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic bad,
    output logic fail
);
    localparam int CW = $clog2(REACT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(REACT_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } filt_s;

    filt_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!bad)
            s_d.cnt = '0;
        else if (s_q.cnt != CNT_MAX)
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign fail = (s_q.cnt == CNT_MAX);

endmodule

// File: rtl/por_tick_timer.sv
module por_tick_timer #(
    parameter int FAST_TICKS = 32,
    parameter int SLOW_TICKS = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    input  logic slow_mode,
    output logic expired
);
    localparam int MAXT = (FAST_TICKS > SLOW_TICKS) ? FAST_TICKS : SLOW_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_TICKS - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;
    logic [CW-1:0] last;

    always_comb begin
        last = slow_mode ? SLOW_LAST : FAST_LAST;
        s_d  = s_q;
        if (clear)
            s_d.cnt = '0;
        else if (tick && (s_q.cnt != last))
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign expired = !clear && tick && (s_q.cnt == last);

endmodule

// File: rtl/dual_rail_por.sv
module dual_rail_por #(
    parameter int FAST_TICKS   = 32,
    parameter int SLOW_TICKS   = 128,
    parameter int REACT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic slow_mode,
    input  logic core_good,
    input  logic io_good,
    output logic por_rst_n,
    output logic rst_released
);
    import por_pkg::*;

    typedef struct packed {
        por_state_e state;
        logic       released;
    } seq_s;

    seq_s s_d, s_q;

    logic [NUM_RAILS-1:0] rail_good;
    logic [NUM_RAILS-1:0] rail_fail;
    logic                 delay_done;
    logic                 timer_clear;

    assign rail_good[RAIL_CORE] = core_good;
    assign rail_good[RAIL_IO]   = io_good;

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_filt
        por_fail_filter #(.REACT_CYCLES(REACT_CYCLES)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .bad  (!rail_good[g]),
            .fail (rail_fail[g])
        );
    end

    assign timer_clear = (s_q.state != ST_DELAY);

    por_tick_timer #(.FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .clear     (timer_clear),
        .tick      (tick),
        .slow_mode (slow_mode),
        .expired   (delay_done)
    );

    always_comb begin
        s_d          = s_q;
        s_d.released = 1'b0;
        case (s_q.state)
            ST_WAIT_CORE: if (core_good) s_d.state = ST_DELAY;
            ST_DELAY: begin
                if (rail_fail[RAIL_CORE])
                    s_d.state = ST_WAIT_CORE;
                else if (delay_done)
                    s_d.state = (io_good && core_good) ? ST_RUN : ST_CHECK_IO;
            end
            ST_CHECK_IO: begin
                if (rail_fail[RAIL_CORE])
                    s_d.state = ST_WAIT_CORE;
                else if (io_good && core_good)
                    s_d.state = ST_RUN;
            end
            ST_RUN: if (|rail_fail) s_d.state = ST_WAIT_CORE;
            default: s_d.state = ST_WAIT_CORE;
        endcase
        if (s_d.state == ST_RUN && s_q.state != ST_RUN)
            s_d.released = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.state    <= ST_WAIT_CORE;
            s_q.released <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign por_rst_n    = (s_q.state == ST_RUN);
    assign rst_released = s_q.released;

endmodule

// File: rtl/por_checker.sv
module por_checker (
    input logic clk,
    input logic rst,
    input logic core_good,
    input logic io_good,
    input logic por_rst_n,
    input logic rst_released
);
    a_r1_low_after_reset: assert property (@(posedge clk) rst |=> (!por_rst_n && !rst_released));

    a_r2_core_bad_holds_low: assert property (@(posedge clk) disable iff (rst)
        (!core_good && !por_rst_n) |=> !por_rst_n);

    a_r5_release_needs_io: assert property (@(posedge clk) disable iff (rst)
        $rose(por_rst_n) |-> $past(io_good));

    a_r6_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(por_rst_n) |-> rst_released);

    a_r6_pulse_only_at_rise: assert property (@(posedge clk) disable iff (rst)
        rst_released |-> (por_rst_n && !$past(por_rst_n)));

    a_r7_drop_needs_bad_rail: assert property (@(posedge clk) disable iff (rst)
        $fell(por_rst_n) |-> $past(!core_good || !io_good));
endmodule

bind dual_rail_por por_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .core_good    (core_good),
    .io_good      (io_good),
    .por_rst_n    (por_rst_n),
    .rst_released (rst_released)
);

// File: tb/dual_rail_por_test.sv
module dual_rail_por_test;
    localparam int FAST  = 4;
    localparam int SLOW  = 9;
    localparam int REACT = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic slow_mode = 1'b0;
    logic core_good = 1'b0;
    logic io_good = 1'b0;
    logic por_rst_n;
    logic rst_released;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_rail_por #(.FAST_TICKS(FAST), .SLOW_TICKS(SLOW), .REACT_CYCLES(REACT)) uut (
        .clk(clk), .rst(rst), .tick(tick), .slow_mode(slow_mode),
        .core_good(core_good), .io_good(io_good),
        .por_rst_n(por_rst_n), .rst_released(rst_released)
    );

    // vector: {slow, io, ticks[7:0], expected por_rst_n}
    localparam logic [10:0] VEC [6] = '{
        {1'b0, 1'b1, 8'd3,  1'b0},
        {1'b0, 1'b1, 8'd4,  1'b1},
        {1'b1, 1'b1, 8'd8,  1'b0},
        {1'b1, 1'b1, 8'd9,  1'b1},
        {1'b0, 1'b0, 8'd4,  1'b0},
        {1'b1, 1'b0, 8'd12, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; cyc(1);
            tick = 1'b0; cyc(2);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; core_good = 1'b0; io_good = 1'b0; tick = 1'b0;
        cyc(2);
        rst = 1'b0;
    endtask

    initial begin
        cyc(1);
        do_reset();
        // R1 reset state
        chk("R1 rst_n after reset", por_rst_n, 1'b0);
        chk("R1 released after reset", rst_released, 1'b0);

        // R2: io good and ticks, core absent
        io_good = 1'b1;
        ticks(SLOW + 2);
        chk("R2 core absent holds reset", por_rst_n, 1'b0);

        // vector table: R3, R4, R5
        for (int v = 0; v < 6; v++) begin
            do_reset();
            slow_mode = VEC[v][10];
            io_good   = VEC[v][9];
            core_good = 1'b1;
            cyc(1);
            ticks(int'(VEC[v][8:1]));
            chk(VEC[v][10] ? "R4 slow delay vector" : "R3 fast delay vector",
                por_rst_n, VEC[v][0]);
        end

        // R5: io late, release without further tick; R6 pulse
        do_reset();
        slow_mode = 1'b0; core_good = 1'b1; io_good = 1'b0;
        cyc(1);
        ticks(FAST + 2);
        chk("R5 waits for io", por_rst_n, 1'b0);
        chk("R6 no pulse while held", rst_released, 1'b0);
        io_good = 1'b1;
        cyc(1);
        chk("R5 release on io good", por_rst_n, 1'b1);
        chk("R6 pulse at release", rst_released, 1'b1);
        cyc(1);
        chk("R6 pulse lasts one cycle", rst_released, 1'b0);

        // R8: short glitch on core and on io
        core_good = 1'b0; cyc(REACT - 1); core_good = 1'b1; cyc(4);
        chk("R8 core glitch ignored", por_rst_n, 1'b1);
        io_good = 1'b0; cyc(REACT - 1); io_good = 1'b1; cyc(4);
        chk("R8 io glitch ignored", por_rst_n, 1'b1);

        // R7: sustained io fail
        io_good = 1'b0; cyc(REACT + 3);
        chk("R7 io fail asserts reset", por_rst_n, 1'b0);
        io_good = 1'b1; cyc(2);
        // R9: full delay after recovery
        ticks(FAST - 1);
        chk("R9 recovery one tick short", por_rst_n, 1'b0);
        ticks(1);
        chk("R9 recovery full delay", por_rst_n, 1'b1);

        // R7: sustained core fail
        core_good = 1'b0; cyc(REACT + 3);
        chk("R7 core fail asserts reset", por_rst_n, 1'b0);

        // R9: core loss during delay restarts count
        core_good = 1'b1; cyc(1);
        ticks(FAST - 1);
        core_good = 1'b0; cyc(REACT + 2);
        core_good = 1'b1; cyc(1);
        ticks(FAST - 1);
        chk("R9 restart during delay short", por_rst_n, 1'b0);
        ticks(1);
        chk("R9 restart during delay full", por_rst_n, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule